// File: doc/BRIEF.md
# Write Handshake Latency and Bandwidth Monitor

This block watches a write path without driving it. It observes two handshakes, the write-data beat and the write response, and for each completed handshake it records how many cycles the source held valid before the sink granted ready. Each of the two channels keeps its own running minimum, maximum, sum and sample count. A valid that is withdrawn before it is accepted raises a sticky error flag for that channel.

Alongside latency, the monitor adds up the bytes carried by accepted data beats. The byte count for a beat is the number of set strobe bits. The running total is moved into a result register each time a programmable window of cycles ends, which gives a bandwidth figure per window. A simple register port sets the window length, clears the statistics and reads every result back.

Top module: `hs_perf_monitor`

## Requirements
- R1: A data-beat latency equals the number of cycles in which data valid was high while data ready was low before the handshake cycle. A handshake in the first cycle of valid records a latency of 0.
- R2: A response latency is measured the same way from response valid and response ready.
- R3: Each channel keeps the minimum, maximum, sum and count of its recorded latencies. When the channel has no samples, its minimum reads all ones (0xFFFF at default width) and the other three fields read 0.
- R4: The two channels are independent. Traffic on one channel never changes the statistics of the other.
- R5: If a valid that was waiting for ready goes low first, a sticky error bit is set. Bit 0 is for data and bit 1 is for response. The abandoned attempt is not recorded as a sample.
- R6: A register write to address 1 returns all statistics and both error bits to their empty state.
- R7: Each accepted data beat adds the number of set strobe bits to the byte total. A beat that is not accepted adds nothing.
- R8: At the last cycle of each window, the byte total is copied into the bandwidth result and the total restarts. A register write to address 0 sets the window length in cycles, and the new window starts with the total discarded. The window length resets to 64.
- R9: Read address map: 0 window length, 1 bandwidth result, 2 error bits, 4 to 7 data min/max/sum/count, 8 to 11 response min/max/sum/count. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_valid | input | 1 | Observed write-data valid |
| wd_ready | input | 1 | Observed write-data ready |
| wd_strb | input | STRB_W | Observed write-data byte strobes |
| wr_resp_valid | input | 1 | Observed write-response valid |
| wr_resp_ready | input | 1 | Observed write-response ready |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wdata | input | RD_W | Register write data |
| reg_rd_addr | input | ADDR_W | Register read address |
| reg_rdata | output | RD_W | Register read data (combinational) |

## Verification
Several checks run in the RTL on every cycle. A handshake taken with no valid in the previous cycle must record zero. An abandoned valid must raise the error bit. A channel with samples must keep its minimum at or below its maximum, and its count must never decrease except on a clear. The window counter must stay below the programmed length. The exact latency values, the channel independence, the strobe byte totals, the timing of the window boundary and the discarding of a partial window on restart can only be shown by the bench. It drives known handshake patterns and reads the registers back.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic [3:0] {
    A_WIN     = 4'd0,
    A_BW      = 4'd1,
    A_ERR     = 4'd2,
    A_D_MIN   = 4'd4,
    A_D_MAX   = 4'd5,
    A_D_SUM   = 4'd6,
    A_D_CNT   = 4'd7,
    A_R_MIN   = 4'd8,
    A_R_MAX   = 4'd9,
    A_R_SUM   = 4'd10,
    A_R_CNT   = 4'd11
  } hpm_addr_e;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/hpm_lat_tracker.sv
module hpm_lat_tracker #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             ready,
  input  logic             clr,
  output logic             rec_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             err_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             waiting, abort;

  always_comb begin
    waiting = (cnt_q != '0);
    abort   = waiting && !valid;
    if (valid && !ready) begin
      cnt_d = (cnt_q == LAT_MAX) ? cnt_q : cnt_q + LAT_W'(1);
    end else begin
      cnt_d = '0;
    end
    if (clr) begin
      err_d = 1'b0;
    end else begin
      err_d = err_q | abort;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign rec_o = valid && ready;
  assign lat_o = cnt_q;
  assign err_o = err_q;

  // R1
  fresh_hs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o && !$past(valid)) |-> (lat_o == '0));

  // R5
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid && !ready) && !valid && !clr) |=> err_o);
endmodule

// File: rtl/hpm_lat_stats.sv
module hpm_lat_stats #(
  parameter int LAT_W = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rec,
  input  logic [LAT_W-1:0] lat,
  output logic [LAT_W-1:0] min_o,
  output logic [LAT_W-1:0] max_o,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LAT_W-1:0] min_q, min_d, max_q, max_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    upd_en = clr || rec;
    min_d  = min_q;
    max_d  = max_q;
    sum_d  = sum_q;
    cnt_d  = cnt_q;
    if (clr) begin
      min_d = '1;
      max_d = '0;
      sum_d = '0;
      cnt_d = '0;
    end else if (rec) begin
      if (lat < min_q) min_d = lat;
      if (lat > max_q) max_d = lat;
      sum_d = sum_q + SUM_W'(lat);
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '1;
      max_q <= '0;
      sum_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      min_q <= min_d;
      max_q <= max_d;
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign min_o = min_q;
  assign max_o = max_q;
  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

  // R3
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (min_q <= max_q));

  // R3
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/hpm_bw_window.sv
module hpm_bw_window #(
  parameter int               STRB_W  = 4,
  parameter int               WIN_W   = 16,
  parameter int               BYTE_W  = 32,
  parameter logic [WIN_W-1:0] DEF_WIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [STRB_W-1:0] strb,
  input  logic              len_we,
  input  logic [WIN_W-1:0]  len_wdata,
  output logic [WIN_W-1:0]  len_o,
  output logic [BYTE_W-1:0] res_o
);
  logic [WIN_W-1:0]  len_q, len_d, wcnt_q, wcnt_d;
  logic [BYTE_W-1:0] acc_q, acc_d, res_q, res_d, beat_bytes;
  logic [WIN_W:0]    wnext;
  logic              win_end, res_en;

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < STRB_W; i++) begin
      beat_bytes = beat_bytes + BYTE_W'(strb[i]);
    end
    if (!beat) beat_bytes = '0;
  end

  always_comb begin
    wnext   = {1'b0, wcnt_q} + (WIN_W+1)'(1);
    win_end = (wnext >= {1'b0, len_q});
    len_d   = len_q;
    wcnt_d  = wcnt_q;
    acc_d   = acc_q;
    res_d   = res_q;
    res_en  = 1'b0;
    if (len_we) begin
      len_d  = len_wdata;
      wcnt_d = '0;
      acc_d  = '0;
    end else if (win_end) begin
      wcnt_d = '0;
      acc_d  = '0;
      res_d  = acc_q + beat_bytes;
      res_en = 1'b1;
    end else begin
      wcnt_d = wnext[WIN_W-1:0];
      acc_d  = acc_q + beat_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= DEF_WIN;
      wcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      len_q  <= len_d;
      wcnt_q <= wcnt_d;
      acc_q  <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign len_o = len_q;
  assign res_o = res_q;

  // R8
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (wcnt_q < len_q));
endmodule

// File: rtl/hs_perf_monitor.sv
module hs_perf_monitor
  import hpm_pkg::*;
#(
  parameter int               STRB_W  = 4,
  parameter int               LAT_W   = 16,
  parameter int               SUM_W   = 32,
  parameter int               CNT_W   = 16,
  parameter int               WIN_W   = 16,
  parameter int               BYTE_W  = 32,
  parameter int               ADDR_W  = 4,
  parameter int               RD_W    = 32,
  parameter logic [WIN_W-1:0] DEF_WIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_valid,
  input  logic              wd_ready,
  input  logic [STRB_W-1:0] wd_strb,
  input  logic              wr_resp_valid,
  input  logic              wr_resp_ready,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [RD_W-1:0]   reg_wdata,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [RD_W-1:0]   reg_rdata
);
  logic [NUM_CH-1:0] ch_valid, ch_ready, ch_rec, ch_err;
  logic [LAT_W-1:0]  ch_lat [NUM_CH];
  logic [LAT_W-1:0]  ch_min [NUM_CH];
  logic [LAT_W-1:0]  ch_max [NUM_CH];
  logic [SUM_W-1:0]  ch_sum [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt [NUM_CH];
  logic              clr_stats, win_we;
  logic [WIN_W-1:0]  win_len;
  logic [BYTE_W-1:0] bw_res;

  assign ch_valid  = {wr_resp_valid, wd_valid};
  assign ch_ready  = {wr_resp_ready, wd_ready};
  assign clr_stats = reg_wr_en && (reg_wr_addr == ADDR_W'(A_BW));
  assign win_we    = reg_wr_en && (reg_wr_addr == ADDR_W'(A_WIN));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hpm_lat_tracker #(.LAT_W(LAT_W)) i_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (ch_valid[c]),
      .ready (ch_ready[c]),
      .clr   (clr_stats),
      .rec_o (ch_rec[c]),
      .lat_o (ch_lat[c]),
      .err_o (ch_err[c])
    );
    hpm_lat_stats #(.LAT_W(LAT_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) i_st (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_stats),
      .rec   (ch_rec[c]),
      .lat   (ch_lat[c]),
      .min_o (ch_min[c]),
      .max_o (ch_max[c]),
      .sum_o (ch_sum[c]),
      .cnt_o (ch_cnt[c])
    );
  end

  hpm_bw_window #(
    .STRB_W(STRB_W), .WIN_W(WIN_W), .BYTE_W(BYTE_W), .DEF_WIN(DEF_WIN)
  ) i_bw (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (wd_valid && wd_ready),
    .strb      (wd_strb),
    .len_we    (win_we),
    .len_wdata (reg_wdata[WIN_W-1:0]),
    .len_o     (win_len),
    .res_o     (bw_res)
  );

  always_comb begin
    case (reg_rd_addr)
      ADDR_W'(A_WIN):   reg_rdata = RD_W'(win_len);
      ADDR_W'(A_BW):    reg_rdata = RD_W'(bw_res);
      ADDR_W'(A_ERR):   reg_rdata = RD_W'(ch_err);
      ADDR_W'(A_D_MIN): reg_rdata = RD_W'(ch_min[0]);
      ADDR_W'(A_D_MAX): reg_rdata = RD_W'(ch_max[0]);
      ADDR_W'(A_D_SUM): reg_rdata = RD_W'(ch_sum[0]);
      ADDR_W'(A_D_CNT): reg_rdata = RD_W'(ch_cnt[0]);
      ADDR_W'(A_R_MIN): reg_rdata = RD_W'(ch_min[1]);
      ADDR_W'(A_R_MAX): reg_rdata = RD_W'(ch_max[1]);
      ADDR_W'(A_R_SUM): reg_rdata = RD_W'(ch_sum[1]);
      ADDR_W'(A_R_CNT): reg_rdata = RD_W'(ch_cnt[1]);
      default:          reg_rdata = '0;
    endcase
  end

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stats |=> (ch_err == '0) && (ch_cnt[0] == '0) && (ch_cnt[1] == '0));
endmodule

// File: tb/test_hs_perf_monitor.sv
module test_hs_perf_monitor;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wd_valid = 1'b0, wd_ready = 1'b0;
  logic [3:0]  wd_strb = '0;
  logic        wr_resp_valid = 1'b0, wr_resp_ready = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rdata;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_perf_monitor i_hs_perf_monitor (
    .clk(clk), .rst_n(rst_n),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_strb(wd_strb),
    .wr_resp_valid(wr_resp_valid), .wr_resp_ready(wr_resp_ready),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wdata(reg_wdata),
    .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata)
  );

  // monitor: pops expected register values and compares
  initial begin
    exp_t it;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      reg_rd_addr = it.addr;
      #1;
      checks++;
      if (reg_rdata !== it.val) begin
        errors++;
        $display("FAIL %s addr %0d: actual %0h expected %0h", it.tag, it.addr, reg_rdata, it.val);
      end
    end
  end

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.addr = a; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic flush();
    wait (exp_q.size() == 0);
    #2;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // ch 0 = data, 1 = response; w cycles of waiting, then accept (or abandon)
  task automatic handshake(input int ch, input int w, input logic [3:0] s, input bit abandon);
    @(negedge clk);
    if (ch == 0) begin wd_valid = 1'b1; wd_strb = s; wd_ready = 1'b0; end
    else begin wr_resp_valid = 1'b1; wr_resp_ready = 1'b0; end
    repeat (w) @(negedge clk);
    if (abandon) begin
      if (ch == 0) wd_valid = 1'b0; else wr_resp_valid = 1'b0;
      @(negedge clk);
    end else begin
      if (ch == 0) wd_ready = 1'b1; else wr_resp_ready = 1'b1;
      @(negedge clk);
      if (ch == 0) begin wd_valid = 1'b0; wd_ready = 1'b0; wd_strb = '0; end
      else begin wr_resp_valid = 1'b0; wr_resp_ready = 1'b0; end
    end
  endtask

  task automatic expect_ch(input int ch, input logic [31:0] mn, input logic [31:0] mx,
                           input logic [31:0] sm, input logic [31:0] ct, input string tag);
    logic [3:0] b;
    b = (ch == 0) ? 4'd4 : 4'd8;
    expect_reg(b,        mn, tag);
    expect_reg(b + 4'd1, mx, tag);
    expect_reg(b + 4'd2, sm, tag);
    expect_reg(b + 4'd3, ct, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R3, R8, R9)
    expect_reg(4'd0, 32'd64, "R8 reset window length");
    expect_reg(4'd1, 32'd0, "R8 reset bandwidth");
    expect_reg(4'd2, 32'd0, "R5 reset error bits");
    expect_ch(0, 32'hFFFF, 0, 0, 0, "R3 reset data stats");
    expect_ch(1, 32'hFFFF, 0, 0, 0, "R3 reset resp stats");
    expect_reg(4'd3, 32'd0, "R9 unused address");
    flush();

    // data latencies 0, 3, 1 (R1, R3)
    handshake(0, 0, 4'hF, 1'b0);
    handshake(0, 3, 4'hF, 1'b0);
    handshake(0, 1, 4'hF, 1'b0);
    expect_ch(0, 0, 3, 4, 3, "R1 data latencies");
    expect_ch(1, 32'hFFFF, 0, 0, 0, "R4 resp untouched by data");
    flush();

    // response latencies 2, 5 (R2, R4)
    handshake(1, 2, 4'h0, 1'b0);
    handshake(1, 5, 4'h0, 1'b0);
    expect_ch(1, 2, 5, 7, 2, "R2 resp latencies");
    expect_ch(0, 0, 3, 4, 3, "R4 data untouched by resp");
    flush();

    // abandoned data valid (R5)
    handshake(0, 2, 4'hF, 1'b1);
    expect_reg(4'd2, 32'd1, "R5 data error bit");
    expect_reg(4'd7, 32'd3, "R5 abandoned not counted");
    flush();
    handshake(1, 4, 4'h0, 1'b1);
    expect_reg(4'd2, 32'd3, "R5 resp error bit");
    expect_reg(4'd11, 32'd2, "R5 abandoned resp not counted");
    flush();

    // clear (R6)
    reg_write(4'd1, 32'd0);
    expect_reg(4'd2, 32'd0, "R6 errors cleared");
    expect_ch(0, 32'hFFFF, 0, 0, 0, "R6 data cleared");
    expect_ch(1, 32'hFFFF, 0, 0, 0, "R6 resp cleared");
    flush();
    handshake(0, 6, 4'hF, 1'b0);
    expect_ch(0, 6, 6, 6, 1, "R3 single sample after clear");
    flush();

    // bandwidth window of 20 (R7, R8)
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 4'd0; reg_wdata = 32'd20;
    @(negedge clk);
    reg_wr_en = 1'b0;
    wd_valid = 1'b1; wd_ready = 1'b1; wd_strb = 4'hF;
    @(negedge clk); wd_strb = 4'h3;
    @(negedge clk); wd_strb = 4'h1;
    @(negedge clk); wd_strb = 4'h0;
    @(negedge clk); wd_ready = 1'b0; wd_strb = 4'hF;
    @(negedge clk); wd_valid = 1'b0; wd_strb = 4'h0;
    repeat (20) @(negedge clk);
    expect_reg(4'd0, 32'd20, "R8 window length written");
    expect_reg(4'd1, 32'd7, "R7 strobe byte total");
    flush();
    repeat (20) @(negedge clk);
    expect_reg(4'd1, 32'd0, "R8 idle window result");
    flush();

    // restart discards partial window (R8)
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 4'd0; reg_wdata = 32'd20;
    @(negedge clk);
    reg_wr_en = 1'b0;
    wd_valid = 1'b1; wd_ready = 1'b1; wd_strb = 4'hF;
    @(negedge clk);
    wd_valid = 1'b0; wd_ready = 1'b0; wd_strb = 4'h0;
    repeat (7) @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 4'd0; reg_wdata = 32'd20;
    @(negedge clk);
    reg_wr_en = 1'b0;
    @(negedge clk);
    wd_valid = 1'b1; wd_ready = 1'b1; wd_strb = 4'h3;
    @(negedge clk);
    wd_valid = 1'b0; wd_ready = 1'b0; wd_strb = 4'h0;
    repeat (22) @(negedge clk);
    expect_reg(4'd1, 32'd2, "R8 restart drops partial total");
    flush();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule